// File: doc/BRIEF.md
# Synchronous Byte Shift Port

This block moves one byte at a time across a two-wire synchronous link made of a shift clock that it drives and one shared, bidirectional data line. It runs on the fast system clock and derives every shift-clock edge from it. The host picks the direction, supplies the byte to send if there is one, and pulses a start strobe. The port then shifts eight bits with the least significant bit first and raises a completion flag. The flag stays up until the host clears it or starts the next transfer.

Each bit occupies a period of twelve system clocks. The shift clock idles high. It drops at the start of every bit period and rises ten clocks later, so it stays high for the last two clocks of the period. When sending, the data line changes only on the clock at which the shift clock falls. This gives ten clocks of setup ahead of the rising edge and two clocks of hold after it. When receiving, the line is sampled on the system-clock edge at which the shift clock is driven high. The data line is modelled as three signals, an output value, an output enable and an input value, and the pad that combines them sits outside the block.

Top module: `sync_shift_port`

## Requirements
- R1: While reset is asserted and whenever the port is idle, `sclk_o` is 1, `sd_oe_o` is 0 and `busy_o` is 0. After reset `done_o` is 0.
- R2: A transfer lasts 8 bit periods of 12 clocks each. Counting the clock edge that accepts the start as edge 0, `sclk_o` after edge n is 0 when n mod 12 is 0 to 9 and 1 when it is 10 or 11. After edge 96 it is 1.
- R3: When sending (`dir_rx_i` = 0 at the start), `sd_o` after edge n (n < 96) equals bit n/12 of the byte captured at the start, where bit 0 is the least significant. The value therefore changes only together with a falling edge of `sclk_o`.
- R4: `sd_oe_o` is 1 after edges 0 to 95 of a send and 0 at all other times, including for the whole of a receive (`dir_rx_i` = 1).
- R5: When receiving, `sd_i` is sampled at edges 10+12k for k = 0..7, and the value sampled at edge 10+12k becomes bit k of `rx_byte_o`. The assembled byte is presented when `done_o` rises.
- R6: A start strobe that arrives while `busy_o` is 1 is ignored. Its direction and byte are ignored with it.
- R7: `busy_o` is 1 after edges 0 to 95. After edge 96, `busy_o` falls and `done_o` rises in the same cycle. `done_o` then holds until it is cleared.
- R8: `done_clr_i` clears `done_o` on the next edge. If a clear coincides with the edge that completes a transfer, the flag is set. An accepted start also clears the flag.
- R9: Asserting reset during a transfer aborts it at once and returns the port to the idle state of R1. A later start then runs normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every shift-clock edge is derived from it |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously upstream |
| start_i | input | 1 | One-cycle request to begin a transfer |
| dir_rx_i | input | 1 | Direction at start: 0 sends, 1 receives |
| tx_byte_i | input | 8 | Byte to send, captured with an accepted start |
| done_clr_i | input | 1 | Clears the completion flag |
| sd_i | input | 1 | Data line value as seen at the pad |
| sclk_o | output | 1 | Shift clock, idles high |
| sd_o | output | 1 | Data value to drive on the line |
| sd_oe_o | output | 1 | Drive enable for the data line |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | Completion flag |
| rx_byte_o | output | 8 | Received byte, least significant bit shifted in first |

## Verification
All outputs come from registers. A start sampled at edge 0 therefore shows up on `busy_o`, `sclk_o`, `sd_oe_o` and the first data bit right after edge 0. Every later change lands after a fixed edge count: the shift clock rises after edge 10+12k and falls after edge 12k. Completion, together with the received byte, appears after edge 96. The bench drives inputs on falling clock edges and compares every output after every one of the 97 edges of each transfer against the edge-count formulas of R2 to R5, for all 256 byte values in each direction. When receiving, the bench holds the true bit on the line only during the one clock before each sampling edge and drives its complement at all other times. A sample taken one clock early or late therefore shows up as a wrong received byte.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic {
    SSP_IDLE  = 1'b0,
    SSP_SHIFT = 1'b1
  } ssp_state_e;
endpackage

// File: rtl/ssp_phase_timer.sv
// Counts system clocks within one bit period and flags the two event edges.
module ssp_phase_timer #(
  parameter int PERIOD = 12,
  parameter int SETUP  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic rise_o,
  output logic bit_end_o
);
  localparam int PW = $clog2(PERIOD);

  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (restart_i) begin
      ph_d = '0;
    end else if (run_i) begin
      if (ph_q == PW'(PERIOD - 1)) ph_d = '0;
      else                         ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  // Edge that drives the shift clock high (end of the setup window).
  assign rise_o    = run_i && (ph_q == PW'(SETUP - 1));
  // Edge that closes the bit period.
  assign bit_end_o = run_i && (ph_q == PW'(PERIOD - 1));
endmodule

// File: rtl/ssp_shifter.sv
// Transmit and receive shift registers, least significant bit first.
module ssp_shifter #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [NBITS-1:0] tx_byte_i,
  input  logic             tx_shift_i,
  input  logic             rx_sample_i,
  input  logic             sd_i,
  output logic             tx_bit_o,
  output logic [NBITS-1:0] rx_byte_o
);
  logic [NBITS-1:0] tx_q, tx_d;
  logic [NBITS-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load_i)          tx_d = tx_byte_i;
    else if (tx_shift_i) tx_d = {1'b0, tx_q[NBITS-1:1]};
  end

  always_comb begin
    rx_d = rx_q;
    if (rx_sample_i) rx_d = {sd_i, rx_q[NBITS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign tx_bit_o  = tx_q[0];
  assign rx_byte_o = rx_q;
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int NBITS  = 8,
  parameter int PERIOD = 12,
  parameter int SETUP  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dir_rx_i,
  input  logic [NBITS-1:0] tx_byte_i,
  input  logic             done_clr_i,
  input  logic             sd_i,
  output logic             sclk_o,
  output logic             sd_o,
  output logic             sd_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [NBITS-1:0] rx_byte_o
);
  import ssp_pkg::*;

  localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1;

  ssp_state_e    state_q, state_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          sclk_q, sclk_d;
  logic          oe_q, oe_d;
  logic          done_q, done_d;
  logic          rxm_q, rxm_d;

  logic start_ok, rise, bit_end, last_bit, finish, tx_bit;

  assign start_ok = (state_q == SSP_IDLE) && start_i;
  assign last_bit = (bit_q == BW'(NBITS - 1));
  assign finish   = bit_end && last_bit;

  ssp_phase_timer #(.PERIOD(PERIOD), .SETUP(SETUP)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (state_q == SSP_SHIFT),
    .restart_i (start_ok),
    .rise_o    (rise),
    .bit_end_o (bit_end)
  );

  ssp_shifter #(.NBITS(NBITS)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (start_ok),
    .tx_byte_i   (tx_byte_i),
    .tx_shift_i  (bit_end && !last_bit),
    .rx_sample_i (rise && rxm_q),
    .sd_i        (sd_i),
    .tx_bit_o    (tx_bit),
    .rx_byte_o   (rx_byte_o)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sclk_d  = sclk_q;
    oe_d    = oe_q;
    done_d  = done_q;
    rxm_d   = rxm_q;
    if (done_clr_i) done_d = 1'b0;
    unique case (state_q)
      SSP_IDLE: begin
        if (start_i) begin
          state_d = SSP_SHIFT;
          bit_d   = '0;
          sclk_d  = 1'b0;
          oe_d    = !dir_rx_i;
          rxm_d   = dir_rx_i;
          done_d  = 1'b0;
        end
      end
      SSP_SHIFT: begin
        if (rise) sclk_d = 1'b1;
        if (finish) begin
          state_d = SSP_IDLE;
          oe_d    = 1'b0;
          done_d  = 1'b1;
        end else if (bit_end) begin
          bit_d  = bit_q + 1'b1;
          sclk_d = 1'b0;
        end
      end
      default: state_d = SSP_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SSP_IDLE;
      bit_q   <= '0;
      sclk_q  <= 1'b1;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      rxm_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sclk_q  <= sclk_d;
      oe_q    <= oe_d;
      done_q  <= done_d;
      rxm_q   <= rxm_d;
    end
  end

  assign sclk_o  = sclk_q;
  assign sd_oe_o = oe_q;
  assign sd_o    = oe_q & tx_bit;
  assign busy_o  = (state_q == SSP_SHIFT);
  assign done_o  = done_q;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int PERIOD = 12,
  parameter int SETUP  = 10
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic done_clr_i,
  input logic sclk_o,
  input logic sd_o,
  input logic sd_oe_o,
  input logic busy_o,
  input logic done_o
);
  localparam int CW = $clog2(PERIOD + 1);

  // Length of the current low phase of the shift clock.
  logic [CW-1:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_cnt <= '0;
    else if (sclk_o)           low_cnt <= '0;
    else if (low_cnt != '1)    low_cnt <= low_cnt + 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (sclk_o && !sd_oe_o));

  assert_low_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> (low_cnt == CW'(SETUP)));

  assert_high_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |=> sclk_o);

  assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && $stable(sclk_o)) |-> $stable(sd_o));

  assert_oe_in_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe_o |-> busy_o);

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (!busy_o || (sd_oe_o == $past(sd_oe_o))));

  assert_done_on_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !done_clr_i && !start_i) |=> done_o);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr_i && !busy_o) |=> !done_o);
endmodule

bind sync_shift_port ssp_checker #(.PERIOD(PERIOD), .SETUP(SETUP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .done_clr_i (done_clr_i),
  .sclk_o     (sclk_o),
  .sd_o       (sd_o),
  .sd_oe_o    (sd_oe_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/sim_sync_shift_port.sv
`timescale 1ns/1ps
module sim_sync_shift_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       dir_rx_i = 1'b0;
  logic [7:0] tx_byte_i = 8'h00;
  logic       done_clr_i = 1'b0;
  logic       sd_i = 1'b0;
  logic       sclk_o, sd_o, sd_oe_o, busy_o, done_o;
  logic [7:0] rx_byte_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sync_shift_port u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_rx_i(dir_rx_i),
    .tx_byte_i(tx_byte_i), .done_clr_i(done_clr_i), .sd_i(sd_i),
    .sclk_o(sclk_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o), .busy_o(busy_o),
    .done_o(done_o), .rx_byte_o(rx_byte_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, "sclk_o", 32'(sclk_o), 32'd1);
    check(req, "sd_oe_o", 32'(sd_oe_o), 32'd0);
    check(req, "busy_o", 32'(busy_o), 32'd0);
  endtask

  // One full transfer; edge 0 accepts the start. poke injects a start
  // during the transfer and a clear on the completing edge.
  task automatic xfer(input logic rx, input logic [7:0] val, input bit poke);
    @(negedge clk);
    start_i = 1'b1; dir_rx_i = rx; tx_byte_i = val; done_clr_i = 1'b0;
    @(posedge clk);
    for (int n = 0; n <= 96; n++) begin
      @(negedge clk);
      start_i = 1'b0; done_clr_i = 1'b0;
      check(poke ? "R2 R6" : "R2", "sclk_o", 32'(sclk_o),
            32'((n == 96) ? 1 : ((n % 12) >= 10)));
      check("R4", "sd_oe_o", 32'(sd_oe_o), 32'((!rx) && (n < 96)));
      if (!rx && n < 96)
        check(poke ? "R3 R6" : "R3", "sd_o", 32'(sd_o), 32'(val[n / 12]));
      check("R7", "busy_o", 32'(busy_o), 32'(n < 96));
      if (n == 0) check("R8", "done_o cleared by start", 32'(done_o), 32'd0);
      if (n == 96) begin
        check(poke ? "R7 R8" : "R7", "done_o", 32'(done_o), 32'd1);
        if (rx) check(poke ? "R5 R6" : "R5", "rx_byte_o", 32'(rx_byte_o), 32'(val));
      end
      if (rx && n < 96) sd_i = ((n % 12) == 9) ? val[n / 12] : ~val[n / 12];
      if (poke && n == 40) begin
        start_i = 1'b1; dir_rx_i = ~rx; tx_byte_i = ~val;
      end
      if (poke && n == 95) done_clr_i = 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    check("R1", "done_o", 32'(done_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    for (int v = 0; v < 256; v++) xfer(1'b0, 8'(v), (v % 16) == 5);
    for (int v = 0; v < 256; v++) xfer(1'b1, 8'(v), (v % 16) == 9);

    repeat (5) @(negedge clk);
    check("R7", "done_o held", 32'(done_o), 32'd1);
    check_idle("R1");
    done_clr_i = 1'b1;
    @(negedge clk);
    done_clr_i = 1'b0;
    check("R8", "done_o after clear", 32'(done_o), 32'd0);

    // Abort by reset during a send.
    start_i = 1'b1; dir_rx_i = 1'b0; tx_byte_i = 8'hA5;
    @(negedge clk);
    start_i = 1'b0;
    repeat (30) @(negedge clk);
    check("R9", "busy_o before abort", 32'(busy_o), 32'd1);
    rst_n = 1'b0;
    #1;
    check_idle("R9");
    check("R9", "done_o", 32'(done_o), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    xfer(1'b0, 8'h3C, 1'b0);
    xfer(1'b1, 8'hC3, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired: actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule